// File: doc/BRIEF.md
# Ethernet PHY Pin Mode Controller

This block stands between the internal receive and transmit symbol paths of an Ethernet PHY and its external media-independent pins. It picks one of two pin personalities: a nibble-wide media-independent interface (MII), or a five-bit raw symbol interface used when the line coder is bypassed. In the five-bit personality the two error pins become the fifth data bit in each direction. In nibble mode the block generates carrier sense, receive data valid, receive error and collision at the pins from internal link, packet and error flags. These signals follow separate rules at 10 and 100 Mbps.

A receive state machine has the states LINK_DOWN, IDLE, CARRIER and DATA. It leaves LINK_DOWN for IDLE when the link is good. From IDLE a start-of-packet flag goes to CARRIER at 10 Mbps, or straight to DATA at 100 Mbps. CARRIER moves to DATA once the recovered clock is in use. An end-of-packet flag returns CARRIER or DATA to IDLE. From every state a failed link forces LINK_DOWN, and reset also enters LINK_DOWN. A disable bit drives the per-signal output enables. It is preset at reset from five address straps and can later be written. A receive-enable pin, once chosen by configuration, can float the receive group on its own.

Top module: `phy_pin_mux`

## Requirements
- R1: With `cfg_bypass` high, `{rx_er_o, rxd_o}` equals the `core_rxd` value from the previous clock, and `core_txd` equals `{tx_er_pin, txd_pin}` in the same cycle.
- R2: With `cfg_bypass` high, `crs_o` is high exactly when the state machine is not in LINK_DOWN, `rx_dv_o` and `col_o` are low, and `core_tx_en` is low whatever `tx_en_pin` does.
- R3: In nibble mode at 10 Mbps (`cfg_speed100` low), `rx_er_o` is always low and `core_tx_er` is low whatever `tx_er_pin` does.
- R4: At 10 Mbps in IDLE, `rxd_o` is 0 and `crs_o` and `rx_dv_o` are low. One clock after `sop_det`, `crs_o` is high and `rx_dv_o` stays low. `rx_dv_o` rises one clock after `clk_locked` is seen in CARRIER.
- R5: At 100 Mbps, `crs_o` and `rx_dv_o` both rise one clock after `sop_det`. In DATA, `rxd_o` and `rx_er_o` show the `core_rxd[3:0]` and `sym_err` values from the previous clock, so the error marks exactly the one errored nibble.
- R6: One clock after `eop_det`, `crs_o` and `rx_dv_o` are low and `rxd_o` is 0. While `link_ok` is low they stay low, even when `sop_det` arrives, and the machine returns to IDLE one clock after `link_ok` comes back.
- R7: If `strap_addr` is all ones in the last reset cycle, the block leaves reset disabled. Any other value leaves it enabled. A `cfg_dis_wr` pulse loads `cfg_dis_val` into the disable bit.
- R8: While disabled, every output enable (`rx_clk_oe`, `rxd_oe`, `rx_dv_oe`, `rx_er_oe`, `col_oe`, `crs_oe`, `tp_oe`) is low and `core_tx_en`, `core_tx_er` and `core_txd` are 0.
- R9: With `cfg_rxen_sel` high and `rxen_pin` low, `rx_clk_oe`, `rxd_oe`, `rx_dv_oe`, `rx_er_oe` and `col_oe` are low, while `crs_oe` and `tp_oe` keep their enabled value.
- R10: In nibble mode with the link up and the block enabled, `tx_en_pin` raises `crs_o` in the same cycle unless `cfg_lb_off` is high.
- R11: In nibble mode `col_o` follows `col_det` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| strap_addr | input | 5 | Address straps sampled during reset |
| cfg_bypass | input | 1 | Coder bypass; selects five-bit personality |
| cfg_speed100 | input | 1 | 1 = 100 Mbps, 0 = 10 Mbps |
| cfg_lb_off | input | 1 | Disables transmit-enable onto carrier loopback |
| cfg_rxen_sel | input | 1 | Gives the receive-enable pin its float function |
| cfg_dis_wr | input | 1 | Write strobe for the disable bit |
| cfg_dis_val | input | 1 | Value written to the disable bit |
| link_ok | input | 1 | Link in pass state |
| sop_det | input | 1 | Start of packet seen on the line |
| clk_locked | input | 1 | Recovered receive clock in use |
| eop_det | input | 1 | End of packet seen on the line |
| sym_err | input | 1 | Error on the current receive nibble |
| col_det | input | 1 | Collision condition |
| core_rxd | input | 5 | Internal receive symbol |
| tx_en_pin | input | 1 | Transmit enable pin |
| tx_er_pin | input | 1 | Transmit error pin / transmit bit 4 |
| txd_pin | input | 4 | Transmit data pins |
| rxen_pin | input | 1 | Receive-enable pin, active low float |
| rxd_o | output | 4 | Receive data pins |
| rx_er_o | output | 1 | Receive error pin / receive bit 4 |
| rx_dv_o | output | 1 | Receive data valid pin |
| crs_o | output | 1 | Carrier sense pin |
| col_o | output | 1 | Collision pin |
| rx_clk_oe | output | 1 | Output enable for receive clock |
| rxd_oe | output | 1 | Output enable for receive data |
| rx_dv_oe | output | 1 | Output enable for data valid |
| rx_er_oe | output | 1 | Output enable for receive error |
| col_oe | output | 1 | Output enable for collision |
| crs_oe | output | 1 | Output enable for carrier sense |
| tp_oe | output | 1 | Twisted-pair transmitter enable |
| core_tx_en | output | 1 | Transmit enable to the core |
| core_tx_er | output | 1 | Transmit error to the core |
| core_txd | output | 5 | Transmit symbol to the core |

## Verification
The assertions assume that reset is held for at least one clock with valid straps, and that configuration bits change only between packets. They also assume that `clk_locked` and `eop_det` are not raised together in CARRIER. The stimulus follows these rules. It moves configuration only while the state machine is in IDLE or LINK_DOWN, and it pulses the packet flags one at a time. Within that space the bench sweeps every strap value, every five-bit receive symbol and every transmit pin pattern.

// File: rtl/phy_pin_pkg.sv
package phy_pin_pkg;
    typedef enum logic [1:0] {
        RS_LINK_DOWN = 2'd0,
        RS_IDLE      = 2'd1,
        RS_CARRIER   = 2'd2,
        RS_DATA      = 2'd3
    } rx_state_t;
endpackage

// File: rtl/phy_rx_fsm.sv
module phy_rx_fsm
    import phy_pin_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic speed_100,
    input  logic link_ok,
    input  logic sop,
    input  logic locked,
    input  logic eop,
    output logic carrier,
    output logic valid,
    output logic link_up
);
    rx_state_t st_q, st_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) st_q <= RS_LINK_DOWN;
        else     st_q <= st_d;
    end

    // transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            RS_LINK_DOWN: if (link_ok) st_d = RS_IDLE;
            RS_IDLE:      if (sop) st_d = speed_100 ? RS_DATA : RS_CARRIER;
            RS_CARRIER: begin
                if (eop)         st_d = RS_IDLE;
                else if (locked) st_d = RS_DATA;
            end
            RS_DATA:      if (eop) st_d = RS_IDLE;
            default:      st_d = RS_LINK_DOWN;
        endcase
        if (!link_ok) st_d = RS_LINK_DOWN;
    end

    // outputs
    always_comb begin
        carrier = 1'b0;
        valid   = 1'b0;
        link_up = 1'b1;
        unique case (st_q)
            RS_LINK_DOWN: link_up = 1'b0;
            RS_IDLE:      ;
            RS_CARRIER:   carrier = 1'b1;
            RS_DATA: begin
                carrier = 1'b1;
                valid   = 1'b1;
            end
            default:      link_up = 1'b0;
        endcase
    end

    // R6: a failed link clears carrier and valid on the next clock
    a_r6_link_fail_quiet: assert property (@(posedge clk) disable iff (rst)
        !link_ok |=> (!carrier && !valid && !link_up));

    // R4: at 10 Mbps valid only rises out of carrier with the clock locked
    a_r4_dv_after_lock: assert property (@(posedge clk) disable iff (rst)
        ($rose(valid) && !$past(speed_100)) |-> ($past(carrier) && $past(locked)));

    // R6: end of packet drops valid on the next clock
    a_r6_eop_drops: assert property (@(posedge clk) disable iff (rst)
        (eop && link_ok && carrier) |=> !valid);
endmodule

// File: rtl/phy_strap_ctl.sv
module phy_strap_ctl #(
    parameter int STRAP_W = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [STRAP_W-1:0] strap,
    input  logic               dis_wr,
    input  logic               dis_val,
    output logic               off
);
    logic off_q;

    // straps follow while in reset; the last reset cycle wins
    always_ff @(posedge clk) begin
        if (rst)         off_q <= &strap;
        else if (dis_wr) off_q <= dis_val;
    end

    assign off = off_q;

    // R7: the disable bit leaving reset reflects the strap pattern
    a_r7_strap_latch: assert property (@(posedge clk)
        ($past(rst) && !rst) |-> (off == $past(&strap)));
endmodule

// File: rtl/phy_tx_map.sv
module phy_tx_map #(
    parameter int SYM_W = 5
) (
    input  logic             off,
    input  logic             fbi,
    input  logic             speed_100,
    input  logic             tx_en,
    input  logic             tx_er,
    input  logic [SYM_W-2:0] txd,
    output logic             core_tx_en,
    output logic             core_tx_er,
    output logic [SYM_W-1:0] core_txd
);
    localparam int NIB_W = SYM_W - 1;

    assign core_tx_en = !off && !fbi && tx_en;
    assign core_tx_er = !off && !fbi && speed_100 && tx_er;

    for (genvar b = 0; b < SYM_W; b++) begin : g_bit
        if (b < NIB_W) begin : g_nib
            assign core_txd[b] = !off && txd[b];
        end else begin : g_top
            assign core_txd[b] = !off && fbi && tx_er;
        end
    end
endmodule

// File: rtl/phy_pin_mux.sv
module phy_pin_mux #(
    parameter int STRAP_W = 5,
    parameter int SYM_W   = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [STRAP_W-1:0] strap_addr,
    input  logic               cfg_bypass,
    input  logic               cfg_speed100,
    input  logic               cfg_lb_off,
    input  logic               cfg_rxen_sel,
    input  logic               cfg_dis_wr,
    input  logic               cfg_dis_val,
    input  logic               link_ok,
    input  logic               sop_det,
    input  logic               clk_locked,
    input  logic               eop_det,
    input  logic               sym_err,
    input  logic               col_det,
    input  logic [SYM_W-1:0]   core_rxd,
    input  logic               tx_en_pin,
    input  logic               tx_er_pin,
    input  logic [SYM_W-2:0]   txd_pin,
    input  logic               rxen_pin,
    output logic [SYM_W-2:0]   rxd_o,
    output logic               rx_er_o,
    output logic               rx_dv_o,
    output logic               crs_o,
    output logic               col_o,
    output logic               rx_clk_oe,
    output logic               rxd_oe,
    output logic               rx_dv_oe,
    output logic               rx_er_oe,
    output logic               col_oe,
    output logic               crs_oe,
    output logic               tp_oe,
    output logic               core_tx_en,
    output logic               core_tx_er,
    output logic [SYM_W-1:0]   core_txd
);
    localparam int NIB_W = SYM_W - 1;

    logic             off, carrier, valid, link_up, rx_grp_en;
    logic [SYM_W-1:0] rxd_q;
    logic             err_q;

    phy_rx_fsm i_fsm (
        .clk(clk), .rst(rst), .speed_100(cfg_speed100), .link_ok(link_ok),
        .sop(sop_det), .locked(clk_locked), .eop(eop_det),
        .carrier(carrier), .valid(valid), .link_up(link_up)
    );

    phy_strap_ctl #(.STRAP_W(STRAP_W)) i_strap (
        .clk(clk), .rst(rst), .strap(strap_addr),
        .dis_wr(cfg_dis_wr), .dis_val(cfg_dis_val), .off(off)
    );

    phy_tx_map #(.SYM_W(SYM_W)) i_tx (
        .off(off), .fbi(cfg_bypass), .speed_100(cfg_speed100),
        .tx_en(tx_en_pin), .tx_er(tx_er_pin), .txd(txd_pin),
        .core_tx_en(core_tx_en), .core_tx_er(core_tx_er), .core_txd(core_txd)
    );

    // one receive pipeline stage keeps data and error on the same cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            rxd_q <= '0;
            err_q <= 1'b0;
        end else begin
            rxd_q <= core_rxd;
            err_q <= sym_err;
        end
    end

    always_comb begin
        if (cfg_bypass) begin
            rxd_o   = rxd_q[NIB_W-1:0];
            rx_er_o = rxd_q[SYM_W-1];
            rx_dv_o = 1'b0;
            col_o   = 1'b0;
            crs_o   = link_up;
        end else begin
            rxd_o   = valid ? rxd_q[NIB_W-1:0] : '0;
            rx_er_o = valid && cfg_speed100 && err_q;
            rx_dv_o = valid;
            col_o   = col_det;
            crs_o   = carrier || (link_up && !off && !cfg_lb_off && tx_en_pin);
        end
    end

    assign rx_grp_en = !off && !(cfg_rxen_sel && !rxen_pin);
    assign rx_clk_oe = rx_grp_en;
    assign rxd_oe    = rx_grp_en;
    assign rx_dv_oe  = rx_grp_en;
    assign rx_er_oe  = rx_grp_en;
    assign col_oe    = rx_grp_en;
    assign crs_oe    = !off;
    assign tp_oe     = !off;

    a_r3_no_err_10m: assert property (@(posedge clk) disable iff (rst)
        (!cfg_bypass && !cfg_speed100) |-> !rx_er_o);

    a_r2_fbi_quiet: assert property (@(posedge clk) disable iff (rst)
        cfg_bypass |-> (!rx_dv_o && !col_o && !core_tx_en));

    a_r8_off_floats: assert property (@(posedge clk) disable iff (rst)
        off |-> !(rx_clk_oe || rxd_oe || rx_dv_oe || rx_er_oe || col_oe
                  || crs_oe || tp_oe || core_tx_en || core_tx_er || (|core_txd)));

    a_r9_rxen_float: assert property (@(posedge clk) disable iff (rst)
        (cfg_rxen_sel && !rxen_pin) |-> !(rx_clk_oe || rxd_oe || rx_dv_oe
                                          || rx_er_oe || col_oe));

    a_r4_dv_has_crs: assert property (@(posedge clk) disable iff (rst)
        (!cfg_bypass && rx_dv_o) |-> crs_o);
endmodule

// File: tb/test_phy_pin_mux.sv
module test_phy_pin_mux;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] strap_addr = '0;
    logic cfg_bypass = 0, cfg_speed100 = 0, cfg_lb_off = 0, cfg_rxen_sel = 0;
    logic cfg_dis_wr = 0, cfg_dis_val = 0;
    logic link_ok = 0, sop_det = 0, clk_locked = 0, eop_det = 0, sym_err = 0, col_det = 0;
    logic [4:0] core_rxd = '0;
    logic tx_en_pin = 0, tx_er_pin = 0, rxen_pin = 1;
    logic [3:0] txd_pin = '0;
    logic [3:0] rxd_o;
    logic rx_er_o, rx_dv_o, crs_o, col_o;
    logic rx_clk_oe, rxd_oe, rx_dv_oe, rx_er_oe, col_oe, crs_oe, tp_oe;
    logic core_tx_en, core_tx_er;
    logic [4:0] core_txd;
    int n_run = 0, n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    phy_pin_mux i_phy_pin_mux (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [6:0] all_oe();
        return {rx_clk_oe, rxd_oe, rx_dv_oe, rx_er_oe, col_oe, crs_oe, tp_oe};
    endfunction

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        tick(); tick(); rst = 0; tick();
        // reset state: link down, enabled
        chk("reset crs/dv R6", {crs_o, rx_dv_o}, 0);
        chk("reset rxd R6", rxd_o, 0);
        chk("reset oe R7", all_oe(), 7'h7f);

        // R7/R8: sweep all strap patterns through reset
        for (int s = 0; s < 32; s++) begin
            strap_addr = 5'(s); txd_pin = 4'hf; tx_en_pin = 1; tx_er_pin = 1;
            rst = 1; tick(); tick(); rst = 0; tick();
            chk("strap R7", tp_oe, (s != 31));
            if (s == 31) begin
                chk("disabled oe R8", all_oe(), 0);
                chk("disabled tx R8", {core_tx_en, core_tx_er, core_txd}, 0);
            end
        end
        cfg_dis_wr = 1; cfg_dis_val = 0; tick(); cfg_dis_wr = 0; #1;
        chk("sw enable R7", all_oe(), 7'h7f);
        tx_en_pin = 0; tx_er_pin = 0; txd_pin = 0;

        // 10 Mbps nibble receive
        link_ok = 1; tick();
        core_rxd = 5'h05; tick();
        chk("idle R4", {rxd_o, crs_o, rx_dv_o}, 0);
        sop_det = 1; tick(); sop_det = 0; #1;
        chk("sop crs R4", {crs_o, rx_dv_o}, 2'b10);
        tick();
        chk("wait lock R4", {crs_o, rx_dv_o}, 2'b10);
        clk_locked = 1; tick();
        chk("lock dv R4", {crs_o, rx_dv_o}, 2'b11);
        chk("data R4", rxd_o, 4'h5);
        sym_err = 1; tx_er_pin = 1; tick();
        chk("10M rx_er R3", rx_er_o, 0);
        chk("10M tx_er R3", core_tx_er, 0);
        sym_err = 0; tx_er_pin = 0;
        eop_det = 1; tick(); eop_det = 0; clk_locked = 0; #1;
        chk("eop R6", {crs_o, rx_dv_o, rxd_o}, 0);

        // 100 Mbps nibble receive with error on one nibble
        cfg_speed100 = 1;
        sop_det = 1; tick(); sop_det = 0; #1;
        chk("100M sop R5", {crs_o, rx_dv_o}, 2'b11);
        for (int k = 0; k < 16; k++) begin
            core_rxd = 5'(k); sym_err = (k == 3); tick();
            chk("100M data R5", {rx_er_o, rxd_o}, {(k == 3), 4'(k)});
        end
        sym_err = 0; tick();
        chk("100M err clear R5", rx_er_o, 0);
        tx_er_pin = 1; #1;
        chk("100M tx_er R5", core_tx_er, 1);
        tx_er_pin = 0;
        col_det = 1; #1;
        chk("col R11", col_o, 1);
        col_det = 0; #1;
        chk("col low R11", col_o, 0);
        link_ok = 0; tick();
        chk("link fail R6", {crs_o, rx_dv_o}, 0);
        sop_det = 1; tick(); sop_det = 0; #1;
        chk("sop in fail R6", {crs_o, rx_dv_o}, 0);
        link_ok = 1; tick();
        chk("back idle R6", {crs_o, rx_dv_o}, 0);

        // loopback
        tx_en_pin = 1; #1;
        chk("loopback R10", crs_o, 1);
        cfg_lb_off = 1; #1;
        chk("loopback off R10", crs_o, 0);
        tx_en_pin = 0; cfg_lb_off = 0;

        // receive enable pin
        cfg_rxen_sel = 1; rxen_pin = 0; #1;
        chk("rxen float R9", all_oe(), 7'b0000011);
        rxen_pin = 1; #1;
        chk("rxen drive R9", all_oe(), 7'h7f);
        cfg_rxen_sel = 0;

        // five-bit personality
        cfg_bypass = 1;
        for (int v = 0; v < 32; v++) begin
            core_rxd = 5'(v); tick();
            chk("fbi rx R1", {rx_er_o, rxd_o}, v);
        end
        tx_en_pin = 1; col_det = 1;
        for (int v = 0; v < 32; v++) begin
            {tx_er_pin, txd_pin} = 5'(v); #1;
            chk("fbi tx R1", core_txd, v);
        end
        chk("fbi flags R2", {crs_o, rx_dv_o, col_o, core_tx_en}, 4'b1000);
        link_ok = 0; tick();
        chk("fbi link down R2", crs_o, 0);
        link_ok = 1; tick();
        chk("fbi link up R2", crs_o, 1);

        // software disable
        cfg_dis_wr = 1; cfg_dis_val = 1; tick(); cfg_dis_wr = 0; #1;
        chk("sw disable R8", all_oe(), 0);
        chk("sw disable tx R8", {core_tx_en, core_tx_er, core_txd}, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule